// File: doc/BRIEF.md
# Byte-Accessible 16-Bit Timer Counter

This block is a 16-bit up-counting timer attached to an 8-bit processor bus. Software reaches the count, the reload value and a control byte one byte at a time through a small address map. While enabled, the counter advances once per prescaler terminal count. When it reaches the reload value, the next tick returns it to 1, toggles the timer output and raises a one-cycle reload pulse.

Software reads the running count in two steps. A read of the high count byte while the timer is enabled copies the live low byte into a holding register. The following low-byte read returns that copy, so the two bytes form one consistent 16-bit value. Writes have no buffering: a byte written to either count address replaces that half of the live counter at the next edge. In edge-start mode, setting the enable bit arms the timer, and counting begins only after a rising edge on the timer input.

Top module: `byte_timer`

## Requirements
- R1: After reset, the count is 0x0000, the reload value is 0xFFFF, the control byte is 0x00, the holding register is 0x00, and both timer output and reload pulse are low.
- R2: The address map is count high at 0, count low at 1, reload high at 2, reload low at 3 and control at 4. In the control byte, bit 0 is enable, bit 1 selects edge-start mode and bits 4:2 select the prescale divide 2^sel, from 1 to 128. Any other address reads 0. While running, the count increases by one every 2^sel clocks, the first tick coming 2^sel clocks after counting starts.
- R3: A tick taken while the count equals the reload value loads 1 on that edge, toggles timerOut and drives reloadPulse high for the following cycle.
- R4: A read of address 0 while enabled stores the live low byte in the holding register at that edge. A read of address 1 while enabled returns the holding register.
- R5: A read of address 1 while disabled returns the live low count byte.
- R6: Reads never change the count or the prescaler progress.
- R7: A byte write to address 0 or 1 replaces that half of the counter at the next edge, and counting continues from the new value. When a high-byte write coincides with a tick, the low half takes the ticked value.
- R8: When a low-byte write coincides with a tick, the written byte wins and no carry from that tick reaches the high byte.
- R9: In edge-start mode, an enabled timer holds its count until a rising edge is sampled on timerIn. The first tick comes 2^sel clocks after the edge that sampled it.
- R10: Clearing enable resets the prescaler and the edge-start arming but keeps the count. A later enable therefore waits a full 2^sel clocks for its first tick.
- R11: The holding register changes only through an address-0 read while enabled. A high read while disabled leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Byte write strobe |
| busRd | input | 1 | Byte read strobe |
| busAddr | input | 3 | Register address |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, combinational from the address |
| timerIn | input | 1 | Timer input, used for edge-start |
| timerOut | output | 1 | Toggles on each reload |
| reloadPulse | output | 1 | One-cycle pulse after each reload |

## Verification
The hardest situation to reach is a low-byte write that lands on the same edge as a tick carrying out of the low byte. The count must sit at 0xFF in its low half, the prescaler must be at its terminal count, and the bus write must all meet on one edge. A directed sequence loads 0x12FF while the timer is disabled, enables it with a divide of 1 and writes the low byte on the very next cycle. A high read and then a low read show whether the carry was dropped. Around the directed cases, seeded random bus traffic runs against a cycle-level model in the bench. It mixes byte writes, reloads of only a few counts, prescale changes and timerIn edges, so writes, reloads and the snapshot logic overlap.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 3;
  localparam int SEL_W   = 3;

  localparam logic [ADDR_W-1:0] ADDR_CNT_HI = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CNT_LO = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_RLD_HI = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_RLD_LO = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 3'd4;

  typedef struct packed {
    logic wrCntHi;
    logic wrCntLo;
    logic wrRldHi;
    logic wrRldLo;
    logic rdCntHi;
    logic tick;
    logic enabled;
  } tmrStrobeT;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int PRE_W = (1 << SEL_W) - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BYTE_W-1:0] busWrData,
  input  logic              timerIn,
  output tmrStrobeT         strobe,
  output logic [BYTE_W-1:0] ctrlByte
);
  logic             enBit, edgeMode, started, prevIn, running, tick;
  logic [SEL_W-1:0] preSel;
  logic [PRE_W-1:0] preCnt, preMask;

  always_comb begin
    for (int i = 0; i < PRE_W; i++) preMask[i] = (i < int'(preSel));
  end

  assign running = enBit && (!edgeMode || started);
  assign tick    = running && ((preCnt & preMask) == preMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enBit    <= 1'b0;
      edgeMode <= 1'b0;
      preSel   <= '0;
    end else if (busWr && busAddr == ADDR_CTRL) begin
      enBit    <= busWrData[0];
      edgeMode <= busWrData[1];
      preSel   <= busWrData[2 +: SEL_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      started <= 1'b0;
      prevIn  <= 1'b0;
    end else begin
      prevIn <= timerIn;
      if (!running || tick) preCnt <= '0;
      else                  preCnt <= preCnt + 1'b1;
      if (!enBit || !edgeMode)       started <= 1'b0;
      else if (timerIn && !prevIn)   started <= 1'b1;
    end
  end

  always_comb begin
    strobe.wrCntHi = busWr && busAddr == ADDR_CNT_HI;
    strobe.wrCntLo = busWr && busAddr == ADDR_CNT_LO;
    strobe.wrRldHi = busWr && busAddr == ADDR_RLD_HI;
    strobe.wrRldLo = busWr && busAddr == ADDR_RLD_LO;
    strobe.rdCntHi = busRd && busAddr == ADDR_CNT_HI;
    strobe.tick    = tick;
    strobe.enabled = enBit;
  end

  assign ctrlByte = BYTE_W'({preSel, edgeMode, enBit});

  // R9: arming happens only after a sampled rising edge on timerIn
  p_start_on_edge_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(started) |-> ($past(timerIn) && !$past(prevIn)));

  // R10: once disabled, the prescaler restarts from zero
  p_pre_cleared_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!enBit && !(busWr && busAddr == ADDR_CTRL)) |=> (preCnt == '0 && !tick));
endmodule

// File: rtl/tmr_dp.sv
module tmr_dp
  import tmr_pkg::*;
#(
  parameter int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobeT         strobe,
  input  logic [BYTE_W-1:0] busWrData,
  output logic [CNT_W-1:0]  cntQ,
  output logic [CNT_W-1:0]  rldQ,
  output logic [BYTE_W-1:0] holdQ,
  output logic              timerOut,
  output logic              reloadPulse
);
  logic [CNT_W-1:0] tickVal, baseVal, cntD;
  logic             atReload;

  assign atReload = (cntQ == rldQ);

  always_comb begin
    tickVal = atReload ? CNT_W'(1) : cntQ + 1'b1;
    baseVal = strobe.tick ? tickVal : cntQ;
    cntD    = baseVal;
    if (strobe.wrCntHi) cntD = {busWrData, baseVal[BYTE_W-1:0]};
    if (strobe.wrCntLo) cntD = {cntQ[CNT_W-1:BYTE_W], busWrData};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ        <= '0;
      rldQ        <= '1;
      holdQ       <= '0;
      timerOut    <= 1'b0;
      reloadPulse <= 1'b0;
    end else begin
      cntQ        <= cntD;
      reloadPulse <= strobe.tick && atReload;
      if (strobe.tick && atReload) timerOut <= ~timerOut;
      if (strobe.wrRldHi) rldQ[CNT_W-1:BYTE_W] <= busWrData;
      if (strobe.wrRldLo) rldQ[BYTE_W-1:0]     <= busWrData;
      if (strobe.rdCntHi && strobe.enabled) holdQ <= cntQ[BYTE_W-1:0];
    end
  end

  // R3: a reload restarts the count at one
  p_reload_restart_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && atReload && !strobe.wrCntHi && !strobe.wrCntLo) |=> cntQ == CNT_W'(1));

  // R3: every reload pulse comes with an output toggle
  p_out_toggle_r3: assert property (@(posedge clk) disable iff (!rstN)
    reloadPulse |-> (timerOut != $past(timerOut)));

  // R2: an ordinary tick advances by one
  p_increment_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && !atReload && !strobe.wrCntHi && !strobe.wrCntLo)
      |=> cntQ == $past(cntQ) + 1'b1);

  // R6: with no tick and no count write, the count holds
  p_count_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.tick && !strobe.wrCntHi && !strobe.wrCntLo) |=> $stable(cntQ));

  // R11: the holding register moves only on an enabled high read
  p_hold_stable_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.rdCntHi && strobe.enabled) |=> $stable(holdQ));
endmodule

// File: rtl/byte_timer.sv
module byte_timer
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BYTE_W-1:0] busWrData,
  output logic [BYTE_W-1:0] busRdData,
  input  logic              timerIn,
  output logic              timerOut,
  output logic              reloadPulse
);
  localparam int CNT_W = 2 * BYTE_W;

  tmrStrobeT         strobe;
  logic [BYTE_W-1:0] ctrlByte, holdQ;
  logic [CNT_W-1:0]  cntQ, rldQ;

  tmr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWrData(busWrData), .timerIn(timerIn), .strobe(strobe), .ctrlByte(ctrlByte)
  );

  tmr_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWrData(busWrData),
    .cntQ(cntQ), .rldQ(rldQ), .holdQ(holdQ),
    .timerOut(timerOut), .reloadPulse(reloadPulse)
  );

  always_comb begin
    unique case (busAddr)
      ADDR_CNT_HI: busRdData = cntQ[CNT_W-1:BYTE_W];
      ADDR_CNT_LO: busRdData = strobe.enabled ? holdQ : cntQ[BYTE_W-1:0];
      ADDR_RLD_HI: busRdData = rldQ[CNT_W-1:BYTE_W];
      ADDR_RLD_LO: busRdData = rldQ[BYTE_W-1:0];
      ADDR_CTRL:   busRdData = ctrlByte;
      default:     busRdData = '0;
    endcase
  end
endmodule

// File: tb/sim_byte_timer.sv
module sim_byte_timer;
  logic       clk = 1'b0, rstN = 1'b0;
  logic       busWr = 0, busRd = 0, timerIn = 0;
  logic [2:0] busAddr = 0;
  logic [7:0] busWrData = 0;
  logic [7:0] busRdData;
  logic       timerOut, reloadPulse;

  byte_timer u0 (.*);

  always #2.5 clk = ~clk;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [7:0] lastRd;

  // reference state, built from the requirements
  logic [15:0] mCnt = 16'h0000, mRld = 16'hFFFF;
  logic [7:0]  mHold = 0;
  logic [6:0]  mPre = 0;
  logic [2:0]  mSel = 0;
  logic        mEn = 0, mEdge = 0, mStarted = 0, mPrev = 0, mOut = 0, mPulse = 0;

  function automatic logic [7:0] modelRd(logic [2:0] a);
    case (a)
      3'd0: return mCnt[15:8];
      3'd1: return mEn ? mHold : mCnt[7:0];
      3'd2: return mRld[15:8];
      3'd3: return mRld[7:0];
      3'd4: return {3'b000, mSel, mEdge, mEn};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string rdTag(logic [2:0] a);
    if (a == 3'd1) return mEn ? "R4" : "R5";
    return "R2";
  endfunction

  task automatic chk(input logic [15:0] got, input logic [15:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic modelStep(input logic wr, input logic rd, input logic [2:0] a,
                           input logic [7:0] d, input logic tin);
    logic [6:0]  mask;
    logic [15:0] base, nxt;
    logic        run, tk;
    mask = 7'((8'd1 << mSel) - 8'd1);
    run  = mEn && (!mEdge || mStarted);
    tk   = run && ((mPre & mask) == mask);
    base = tk ? ((mCnt == mRld) ? 16'd1 : mCnt + 16'd1) : mCnt;
    nxt  = base;
    if (wr && a == 3'd0) nxt = {d, base[7:0]};
    if (wr && a == 3'd1) nxt = {mCnt[15:8], d};
    if (rd && a == 3'd0 && mEn) mHold = mCnt[7:0];
    mPulse = tk && (mCnt == mRld);
    if (mPulse) mOut = ~mOut;
    mCnt = nxt;
    mPre = (!run || tk) ? 7'd0 : mPre + 7'd1;
    if (!mEn || !mEdge) mStarted = 0;
    else if (tin && !mPrev) mStarted = 1;
    mPrev = tin;
    if (wr && a == 3'd2) mRld[15:8] = d;
    if (wr && a == 3'd3) mRld[7:0] = d;
    if (wr && a == 3'd4) begin mEn = d[0]; mEdge = d[1]; mSel = d[4:2]; end
  endtask

  task automatic cyc(input logic wr, input logic rd, input logic [2:0] a,
                     input logic [7:0] d, input logic tin);
    @(negedge clk);
    busWr = wr; busRd = rd; busAddr = a; busWrData = d; timerIn = tin;
    #1;
    lastRd = busRdData;
    chk(16'(busRdData), 16'(modelRd(a)), rdTag(a));
    chk(16'(timerOut), 16'(mOut), "R3 timerOut");
    chk(16'(reloadPulse), 16'(mPulse), "R3 reloadPulse");
    @(posedge clk);
    modelStep(wr, rd, a, d, tin);
  endtask

  task automatic wrB(input logic [2:0] a, input logic [7:0] d);
    cyc(1, 0, a, d, timerIn);
  endtask

  task automatic rdB(input logic [2:0] a);
    cyc(0, 1, a, 8'h00, timerIn);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: reset values
    rdB(0); chk(16'(lastRd), 16'h00, "R1 cnt hi");
    rdB(1); chk(16'(lastRd), 16'h00, "R1 cnt lo");
    rdB(2); chk(16'(lastRd), 16'hFF, "R1 rld hi");
    rdB(3); chk(16'(lastRd), 16'hFF, "R1 rld lo");
    rdB(4); chk(16'(lastRd), 16'h00, "R1 ctrl");
    chk(16'(timerOut), 16'h0, "R1 timerOut");

    // R8: low write on the same edge as a carrying tick
    wrB(0, 8'h12); wrB(1, 8'hFF); wrB(4, 8'h01);
    wrB(1, 8'h55);
    rdB(0); chk(16'(lastRd), 16'h12, "R8 carry dropped hi");
    rdB(1); chk(16'(lastRd), 16'h55, "R8/R4 snapshot lo");

    // R7: high write while running
    wrB(0, 8'h40);
    rdB(0); chk(16'(lastRd), 16'h40, "R7 hi written");
    rdB(1); chk(16'(lastRd), 16'h58, "R7 counting continued");
    wrB(4, 8'h00);
    rdB(1); chk(16'(lastRd), 16'h5B, "R5 live lo when disabled");

    // R11: disabled high read leaves the holding register alone
    rdB(0); wrB(4, 8'h01);
    rdB(1); chk(16'(lastRd), 16'h58, "R11 hold unchanged");
    wrB(4, 8'h00);

    // R3: reload at 3
    wrB(2, 8'h00); wrB(3, 8'h03); wrB(0, 8'h00); wrB(1, 8'h02); wrB(4, 8'h01);
    rdB(0); rdB(0);
    rdB(0); chk(16'(reloadPulse), 16'h1, "R3 pulse"); chk(16'(timerOut), 16'h1, "R3 toggle");
    rdB(0); chk(16'(reloadPulse), 16'h0, "R3 pulse one cycle");
    wrB(4, 8'h00);

    // R9: edge-start waits for timerIn
    wrB(0, 8'h00); wrB(1, 8'h00); wrB(4, 8'h03);
    for (int i = 0; i < 8; i++) rdB(0);
    wrB(4, 8'h00);
    rdB(1); chk(16'(lastRd), 16'h00, "R9 no count before edge");
    wrB(4, 8'h03);
    cyc(0, 0, 3'd0, 8'h00, 1'b1);
    cyc(0, 0, 3'd0, 8'h00, 1'b1);
    cyc(0, 0, 3'd0, 8'h00, 1'b1);
    cyc(1, 0, 3'd4, 8'h00, 1'b0);
    rdB(1); chk(16'(lastRd), 16'h03, "R9 counts after edge");

    // R10 and R2: prescale 4, disable clears the prescaler
    wrB(0, 8'h00); wrB(1, 8'h00); wrB(4, 8'h09);
    rdB(0); rdB(0); wrB(4, 8'h00);
    rdB(0); wrB(4, 8'h09);
    rdB(0); rdB(0); wrB(4, 8'h00);
    rdB(1); chk(16'(lastRd), 16'h00, "R10 prescaler cleared");
    wrB(4, 8'h09);
    rdB(0); rdB(0); rdB(0); wrB(4, 8'h00);
    rdB(1); chk(16'(lastRd), 16'h01, "R2 one tick per 4 clocks");

    // R6: reads while running do not disturb counting
    wrB(0, 8'h00); wrB(1, 8'h00); wrB(2, 8'hFF); wrB(3, 8'hFF); wrB(4, 8'h01);
    for (int i = 0; i < 6; i++) begin rdB(0); rdB(1); end
    wrB(4, 8'h00);
    rdB(1); chk(16'(lastRd), 16'h0D, "R6 count after reads");

    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      int r;
      logic tin;
      r = int'($urandom_range(0, 15));
      tin = ($urandom_range(0, 7) == 0) ? ~timerIn : timerIn;
      if (r < 8)       cyc(0, 1, 3'($urandom_range(0, 5)), 8'h00, tin);
      else if (r < 10) cyc(1, 0, 3'($urandom_range(0, 1)), 8'($urandom), tin);
      else if (r == 10) cyc(1, 0, 3'd2, 8'h00, tin);
      else if (r == 11) cyc(1, 0, 3'd3, 8'($urandom_range(2, 40)), tin);
      else if (r == 12) cyc(1, 0, 3'd4, {3'b000, 3'($urandom_range(0, 2)),
                                          1'($urandom), ($urandom_range(0, 5) != 0)}, tin);
      else             cyc(0, 0, 3'($urandom_range(0, 7)), 8'h00, tin);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule